// File: doc/BRIEF.md
# Interrupt Destination Router

The router takes a set of interrupt request lines and steers each one to a single target. Each source has its own four-bit destination field with one bit per target. The targets are two core interrupt outputs, a critical interrupt output and an off-chip request pin. Requests steered to a core are captured in that core's pending vector. The core output stays high until software clears the captured bit. Requests steered to the critical output or to the off-chip pin pass straight through as level signals, with no latching.

Two message flags sit after the external lines and act as extra sources. A bus write raises a flag and a bus read of the same flag drops it. The internal lines carry fixed numbers:

- Index 1 is the error manager.
- Index 3 is the local bus controller.
- Index 0 is the L2 cache.
- Index 2 is the DRAM controller.
- Indices 4 to 7 are four DMA channels.

A small register bus programs the destinations and reads back the pending, message and error state.

Top module: `irqDestRouter`

## Requirements
- R1: After reset, every destination field holds 4'b0001 (first core). Both pending vectors, both message flags and the error flags are zero, and all four interrupt outputs are low.
- R2: Destination bit 0 selects the first core, bit 1 the second core, bit 2 the critical output and bit 3 the off-chip pin. A source reaches a target only when its field has exactly that one bit set.
- R3: `extIrq` is high in the same cycle as any active source whose field is 4'b1000, and low otherwise. Such a source sets no pending bit.
- R4: `critIrq` is high in the same cycle as any active source whose field is 4'b0100, and low otherwise. Such a source sets no pending bit.
- R5: A source that is active at a clock edge with a field of 4'b0001 (or 4'b0010) sets its own bit in pending vector 0 (or 1) at that edge. `intCore0` (or `intCore1`) is high whenever its pending vector is non-zero.
- R6: Writing a 1 to a bit of a pending vector clears that bit, but only if its source is inactive in the cycle of the write. An active source keeps the bit set.
- R7: A field with zero set bits or with more than one set bit routes the source nowhere. It also sets that source's bit in the error vector, and this bit stays set until reset.
- R8: Source index NUM_SRC+k is message flag k. A write to the flag's address sets it. A read returns the flag in bit 0 and then clears it. When a write and a read of the same flag fall in one cycle, the write wins and the read returns the old value.
- R9: The address map is as follows:
  - Addresses 0 to NTOT-1 hold the destination fields, in bits 3:0.
  - Address NTOT is pending vector 0, and NTOT+1 is pending vector 1.
  - Address NTOT+2 is message 0, and NTOT+3 is message 1.
  - Address NTOT+4 is the error vector.

  A write takes effect at the next edge. Read data appears on `busRdData` one cycle after `busRd`. Unused bits and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIrq | input | NUM_SRC | Level interrupt requests from the internal sources |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Register word address |
| busWrData | input | NUM_SRC+2 | Write data |
| busRdData | output | NUM_SRC+2 | Read data, valid the cycle after busRd |
| intCore0 | output | 1 | First core interrupt |
| intCore1 | output | 1 | Second core interrupt |
| critIrq | output | 1 | Critical interrupt, level |
| extIrq | output | 1 | Off-chip interrupt request, level |

## Verification
Two pairs of functions can land in the same cycle:

- A software clear of a pending bit while the source that set it is still asserted. The bench holds the request high, issues the write-one clear and expects the core output to stay up. It then drops the request and expects the next clear to take effect.
- A message write and a message read that hit the same flag together. The bench drives both strobes at one address. It expects the old flag value on the read data and the flag to remain set on the following read.

Random traffic covers the rest. It mixes destination rewrites, clears and reads with toggling requests, and compares every output each cycle with a model kept in the bench.

// File: rtl/irqRouterPkg.sv
package irqRouterPkg;
  localparam int DEST_W    = 4;
  localparam int CORE0_BIT = 0;
  localparam int CORE1_BIT = 1;
  localparam int CRIT_BIT  = 2;
  localparam int EXT_BIT   = 3;
  localparam logic [DEST_W-1:0] DEST_RESET = 4'b0001;
  localparam int MSG_CNT   = 2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DEST,
    RD_PEND0,
    RD_PEND1,
    RD_MSG,
    RD_ERR
  } rdSel_e;

  typedef struct packed {
    logic               destWr;
    logic               pend0Clr;
    logic               pend1Clr;
    logic [MSG_CNT-1:0] msgSet;
    logic [MSG_CNT-1:0] msgTake;
    logic               rdStb;
    rdSel_e             rdSel;
    logic               rdMsgSel;
  } busStrobe_t;
endpackage

// File: rtl/irqRouteCtrl.sv
module irqRouteCtrl
  import irqRouterPkg::*;
#(
  parameter int NTOT   = 10,
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 4
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe,
  output logic [IDX_W-1:0]  regIdx
);
  localparam logic [ADDR_W-1:0] DEST_END = ADDR_W'(NTOT);
  localparam logic [ADDR_W-1:0] PEND0_A  = ADDR_W'(NTOT);
  localparam logic [ADDR_W-1:0] PEND1_A  = ADDR_W'(NTOT + 1);
  localparam logic [ADDR_W-1:0] MSG0_A   = ADDR_W'(NTOT + 2);
  localparam logic [ADDR_W-1:0] MSG1_A   = ADDR_W'(NTOT + 3);
  localparam logic [ADDR_W-1:0] ERR_A    = ADDR_W'(NTOT + 4);

  assign regIdx = IDX_W'(busAddr);

  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_NONE;
    if (busWr) begin
      if (busAddr < DEST_END)     strobe.destWr    = 1'b1;
      else if (busAddr == PEND0_A) strobe.pend0Clr = 1'b1;
      else if (busAddr == PEND1_A) strobe.pend1Clr = 1'b1;
      else if (busAddr == MSG0_A)  strobe.msgSet[0] = 1'b1;
      else if (busAddr == MSG1_A)  strobe.msgSet[1] = 1'b1;
    end
    if (busRd) begin
      strobe.rdStb = 1'b1;
      if (busAddr < DEST_END)      strobe.rdSel = RD_DEST;
      else if (busAddr == PEND0_A) strobe.rdSel = RD_PEND0;
      else if (busAddr == PEND1_A) strobe.rdSel = RD_PEND1;
      else if (busAddr == MSG0_A) begin
        strobe.rdSel      = RD_MSG;
        strobe.msgTake[0] = 1'b1;
      end else if (busAddr == MSG1_A) begin
        strobe.rdSel      = RD_MSG;
        strobe.rdMsgSel   = 1'b1;
        strobe.msgTake[1] = 1'b1;
      end else if (busAddr == ERR_A) strobe.rdSel = RD_ERR;
    end
  end
endmodule

// File: rtl/irqRouteDatapath.sv
module irqRouteDatapath
  import irqRouterPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NTOT    = 10,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  busStrobe_t         strobe,
  input  logic [IDX_W-1:0]   regIdx,
  input  logic [NTOT-1:0]    wrData,
  output logic [NTOT-1:0]    rdData,
  output logic               intCore0,
  output logic               intCore1,
  output logic               critIrq,
  output logic               extIrq
);
  logic [DEST_W-1:0]  destReg [NTOT];
  logic [MSG_CNT-1:0] msgFlag;
  logic [NTOT-1:0]    srcAll, validVec;
  logic [NTOT-1:0]    routeCore0, routeCore1, routeCrit, routeExt;
  logic [NTOT-1:0]    pend0, pend1, cfgErr;
  logic [NTOT-1:0]    clrMask0, clrMask1;

  assign srcAll = {msgFlag, srcIrq};

  for (genvar i = 0; i < NTOT; i++) begin : gSrc
    always_ff @(posedge clk) begin
      if (!rstN) destReg[i] <= DEST_RESET;
      else if (strobe.destWr && regIdx == IDX_W'(i)) destReg[i] <= wrData[DEST_W-1:0];
    end
    assign validVec[i]   = $onehot(destReg[i]);
    assign routeCore0[i] = srcAll[i] & validVec[i] & destReg[i][CORE0_BIT];
    assign routeCore1[i] = srcAll[i] & validVec[i] & destReg[i][CORE1_BIT];
    assign routeCrit[i]  = srcAll[i] & validVec[i] & destReg[i][CRIT_BIT];
    assign routeExt[i]   = srcAll[i] & validVec[i] & destReg[i][EXT_BIT];

    // R5
    core_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
      routeCore0[i] |=> pend0[i]);
    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pend1[i] && srcAll[i]) |=> pend1[i]);
    // R7
    cfg_err_chk: assert property (@(posedge clk) disable iff (!rstN)
      !validVec[i] |=> cfgErr[i]);
  end

  for (genvar k = 0; k < MSG_CNT; k++) begin : gMsg
    always_ff @(posedge clk) begin
      if (!rstN) msgFlag[k] <= 1'b0;
      else if (strobe.msgSet[k]) msgFlag[k] <= 1'b1;
      else if (strobe.msgTake[k]) msgFlag[k] <= 1'b0;
    end
    // R8
    msg_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.msgSet[k] |=> msgFlag[k]);
    // R8
    msg_take_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.msgTake[k] && !strobe.msgSet[k]) |=> !msgFlag[k]);
  end

  assign clrMask0 = (strobe.pend0Clr ? wrData : '0) & ~srcAll;
  assign clrMask1 = (strobe.pend1Clr ? wrData : '0) & ~srcAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend0  <= '0;
      pend1  <= '0;
      cfgErr <= '0;
    end else begin
      pend0  <= (pend0 & ~clrMask0) | routeCore0;
      pend1  <= (pend1 & ~clrMask1) | routeCore1;
      cfgErr <= cfgErr | ~validVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdStb) begin
      unique case (strobe.rdSel)
        RD_DEST:  rdData <= NTOT'(destReg[regIdx]);
        RD_PEND0: rdData <= pend0;
        RD_PEND1: rdData <= pend1;
        RD_MSG:   rdData <= NTOT'(msgFlag[strobe.rdMsgSel]);
        RD_ERR:   rdData <= cfgErr;
        default:  rdData <= '0;
      endcase
    end
  end

  assign intCore0 = |pend0;
  assign intCore1 = |pend1;
  assign critIrq  = |routeCrit;
  assign extIrq   = |routeExt;

  // R5
  core_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intCore1) |-> $past(|routeCore1));
endmodule

// File: rtl/irqDestRouter.sv
module irqDestRouter
  import irqRouterPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 5,
  localparam int NTOT   = NUM_SRC + MSG_CNT,
  localparam int IDX_W  = $clog2(NTOT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NTOT-1:0]    busWrData,
  output logic [NTOT-1:0]    busRdData,
  output logic               intCore0,
  output logic               intCore1,
  output logic               critIrq,
  output logic               extIrq
);
  busStrobe_t       strobe;
  logic [IDX_W-1:0] regIdx;

  irqRouteCtrl #(.NTOT(NTOT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .busWr  (busWr),
    .busRd  (busRd),
    .busAddr(busAddr),
    .strobe (strobe),
    .regIdx (regIdx)
  );

  irqRouteDatapath #(.NUM_SRC(NUM_SRC), .NTOT(NTOT), .IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIrq  (srcIrq),
    .strobe  (strobe),
    .regIdx  (regIdx),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .intCore0(intCore0),
    .intCore1(intCore1),
    .critIrq (critIrq),
    .extIrq  (extIrq)
  );
endmodule

// File: tb/irqDestRouter_tb.sv
module irqDestRouter_tb;
  localparam int NS = 8;
  localparam int NT = NS + 2;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic [NS-1:0] src;
  logic bWr, bRd;
  logic [AW-1:0] bAddr;
  logic [NT-1:0] bWd;
  logic [NT-1:0] bRdData;
  logic int0, int1, crit, ext;

  irqDestRouter #(.NUM_SRC(NS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .srcIrq(src), .busWr(bWr), .busRd(bRd),
    .busAddr(bAddr), .busWrData(bWd), .busRdData(bRdData),
    .intCore0(int0), .intCore1(int1), .critIrq(crit), .extIrq(ext)
  );

  logic [3:0]    mDest [NT];
  logic [NT-1:0] mPend0, mPend1, mErr;
  logic [1:0]    mMsg;
  int checks = 0;
  int errors = 0;
  logic [NT-1:0] lastRd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NT-1:0] routeVec(int pos, logic [NT-1:0] s);
    logic [NT-1:0] r = '0;
    for (int i = 0; i < NT; i++)
      if ($countones(mDest[i]) == 1 && mDest[i][pos] && s[i]) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [NT-1:0] readModel(logic [AW-1:0] a);
    if (a < NT)            return NT'(mDest[a]);
    else if (a == NT)      return mPend0;
    else if (a == NT + 1)  return mPend1;
    else if (a == NT + 2)  return NT'(mMsg[0]);
    else if (a == NT + 3)  return NT'(mMsg[1]);
    else if (a == NT + 4)  return mErr;
    return '0;
  endfunction

  task automatic cycle();
    logic [NT-1:0] sAll, expRd, nP0, nP1, nErr, c0, c1;
    logic [1:0] nMsg;
    logic doRd;
    #1;
    sAll = {mMsg, src};
    chk("R4 crit level", crit, |routeVec(2, sAll));
    chk("R3 ext level", ext, |routeVec(3, sAll));
    chk("R5 core0 out", int0, |mPend0);
    chk("R5 core1 out", int1, |mPend1);
    doRd  = bRd;
    expRd = readModel(bAddr);
    c0 = (bWr && bAddr == NT)     ? (bWd & ~sAll) : '0;
    c1 = (bWr && bAddr == NT + 1) ? (bWd & ~sAll) : '0;
    nP0 = (mPend0 & ~c0) | routeVec(0, sAll);
    nP1 = (mPend1 & ~c1) | routeVec(1, sAll);
    nErr = mErr;
    for (int i = 0; i < NT; i++) if ($countones(mDest[i]) != 1) nErr[i] = 1'b1;
    nMsg = mMsg;
    for (int k = 0; k < 2; k++) begin
      if (bRd && bAddr == AW'(NT + 2 + k)) nMsg[k] = 1'b0;
      if (bWr && bAddr == AW'(NT + 2 + k)) nMsg[k] = 1'b1;
    end
    @(posedge clk);
    if (bWr && bAddr < NT) mDest[bAddr] = bWd[3:0];
    mPend0 = nP0; mPend1 = nP1; mErr = nErr; mMsg = nMsg;
    @(negedge clk);
    if (doRd) begin
      chk("R9 read data", bRdData, expRd);
      lastRd = bRdData;
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NT-1:0] d);
    bWr = 1'b1; bAddr = a; bWd = d;
    cycle();
    bWr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    bRd = 1'b1; bAddr = a;
    cycle();
    bRd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'd1234);
    rstN = 1'b0; src = '0; bWr = 1'b0; bRd = 1'b0; bAddr = '0; bWd = '0;
    for (int i = 0; i < NT; i++) mDest[i] = 4'b0001;
    mPend0 = '0; mPend1 = '0; mErr = '0; mMsg = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset outputs and registers
    chk("R1 outputs low", {int0, int1, crit, ext}, 4'b0);
    for (int i = 0; i < NT; i++) begin
      rd(AW'(i));
      chk("R1 dest default", lastRd, 1);
    end
    rd(AW'(NT)); chk("R1 pend0 zero", lastRd, 0);
    rd(AW'(NT + 4)); chk("R1 err zero", lastRd, 0);

    // R2 second core steering
    wr(3, 4'b0010);
    src[3] = 1'b1; cycle(); src[3] = 1'b0;
    chk("R2 core1 raised", int1, 1);
    chk("R2 core0 untouched", int0, 0);
    rd(AW'(NT + 1)); chk("R2 pend1 bit3", lastRd, 10'h008);
    wr(AW'(NT + 1), '1);
    chk("R6 clear idle source", int1, 0);

    // R6 clear collides with active source
    wr(5, 4'b0001);
    src[5] = 1'b1; cycle();
    wr(AW'(NT), 10'h020);
    chk("R6 clear blocked", int0, 1);
    src[5] = 1'b0;
    wr(AW'(NT), 10'h020);
    chk("R6 clear after drop", int0, 0);

    // R3 / R4 level paths
    wr(6, 4'b1000); wr(7, 4'b0100);
    src[6] = 1'b1; #1;
    chk("R3 ext same cycle", ext, 1);
    cycle();
    chk("R3 no pending", int0, 0);
    src[6] = 1'b0; src[7] = 1'b1; #1;
    chk("R4 crit same cycle", crit, 1);
    chk("R3 ext drops", ext, 0);
    cycle(); src[7] = 1'b0; #1;
    chk("R4 crit drops", crit, 0);

    // R7 invalid destinations
    wr(4, 4'b0011);
    src[4] = 1'b1; cycle(); cycle();
    chk("R7 routed nowhere", {int0, int1, crit, ext}, 4'b0);
    src[4] = 1'b0;
    wr(4, 4'b0001);
    rd(AW'(NT + 4)); chk("R7 sticky error", lastRd, 10'h010);

    // R8 message flags
    wr(AW'(NT + 2), '0);
    cycle();
    chk("R8 msg0 to core0", int0, 1);
    rd(AW'(NT + 2)); chk("R8 msg0 read set", lastRd, 1);
    rd(AW'(NT + 2)); chk("R8 msg0 cleared", lastRd, 0);
    bWr = 1'b1; bRd = 1'b1; bAddr = AW'(NT + 3); bWd = '0;
    cycle();
    bWr = 1'b0; bRd = 1'b0;
    chk("R8 collide old value", lastRd, 0);
    rd(AW'(NT + 3)); chk("R8 write wins", lastRd, 1);
    wr(AW'(NT), '1);
    chk("R6 msg pending cleared", int0, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      r = $urandom;
      src = NS'($urandom);
      bWr = (r % 10) < 2;
      bRd = ((r / 10) % 10) < 3;
      bAddr = AW'($urandom % 16);
      if (bAddr < NT && ($urandom % 8) != 0) bWd = NT'(1 << ($urandom % 4));
      else bWd = NT'($urandom);
      cycle();
      bWr = 1'b0; bRd = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule